// File: doc/BRIEF.md
# Wraparound Per-Slot Operand Stack

This block is a small register-file stack that belongs to one execution slot of a parallel-issue core. Its two upper entries are presented at all times as dedicated outputs, so the slot's arithmetic unit can use the top as its implied operand and the entry below it as an optional second operand without a read cycle. Every clock the slot issues one of five requests: leave the stack as it is, push a word, pop a word, overwrite the top, or drop the second entry while writing a new top. The last request is what a binary operation that uses the second entry as its source needs.

The stack has no memory behind it and raises no fault. A circular pointer selects the top entry and wraps in both directions. Pushing past the capacity overwrites the oldest entry. Popping below the bottom exposes whatever entry the wrapped pointer lands on. Arbitration between slots and spilling to memory are handled elsewhere.

Top module: `wrap_stack`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the pointer and every entry are cleared, so after that edge `top_o` and `second_o` both read 0.
- R2: Operation code 0 (idle) and the unused codes 5, 6 and 7 leave the pointer and all entries unchanged. `top_o` and `second_o` keep their values on the next cycle and later.
- R3: Operation code 1 (push) writes `wdata_i` as the new top. The previous top becomes the new second entry one cycle later.
- R4: Operation code 2 (pop) removes the top. The previous second entry becomes the new top one cycle later, and nothing is written.
- R5: Operation code 3 (replace top) writes `wdata_i` into the top entry. The pointer does not move, so `second_o` is unchanged.
- R6: Operation code 4 (pop and replace) consumes the second entry and writes `wdata_i` in its place as the new top within one cycle. The stack shrinks by one.
- R7: The stack holds DEPTH (default 8) entries and the pointer wraps modulo DEPTH. A push onto a full stack silently overwrites the oldest entry.
- R8: A pop or pop-and-replace below the bottom raises no error. The pointer wraps, and the outputs show the entries at the wrapped positions: after a reset followed by one pop, both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code: 0 idle, 1 push, 2 pop, 3 replace top, 4 pop and replace; 5 to 7 idle |
| wdata_i | input | WIDTH (32) | Word written by push, replace top and pop-and-replace |
| top_o | output | WIDTH (32) | Current top entry |
| second_o | output | WIDTH (32) | Entry directly below the top |

## Verification
A pointer that moves the wrong way, or moves when it should not, shows up at once: `top_o` and `second_o` stop matching the previous top, second entry or write data within one cycle. A write to the wrong entry may stay hidden for as many pops as it lies below the top, up to DEPTH-1 operations. For that reason the bench runs long mixed sequences and deliberate wraps in both directions, so that every entry reaches the outputs again. It also replays every three-operation sequence over all eight codes from reset, which covers each transition pair near the wrap boundary.

// File: rtl/wrap_stack_pkg.sv
// Shared operation codes and types for the per-slot wraparound stack.
// Assumes a 3-bit operation field; codes above OP_POP_SET mean idle.
package wrap_stack_pkg;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_PUSH    = 3'd1,
        OP_POP     = 3'd2,
        OP_SET_TOP = 3'd3,
        OP_POP_SET = 3'd4
    } stk_op_e;

    // Decoded control for one cycle
    typedef struct packed {
        logic inc;     // pointer moves up by one
        logic dec;     // pointer moves down by one
        logic wr;      // an entry is written
        logic wr_dn;   // the write targets the entry below the current top
        logic wr_up;   // the write targets the entry above the current top
    } stk_ctl_t;

endpackage

// File: rtl/wrap_stack_dec.sv
// Operation decoder: turns the raw operation code into pointer and
// write controls. Assumes unknown codes are treated as idle.
module wrap_stack_dec
    import wrap_stack_pkg::*;
(
    input  logic [2:0] op_i,
    output stk_ctl_t   ctl_o
);

    // Map each operation to its pointer move and write target
    always_comb begin
        ctl_o = '0;
        case (op_i)
            OP_PUSH: begin
                ctl_o.inc   = 1'b1;
                ctl_o.wr    = 1'b1;
                ctl_o.wr_up = 1'b1;
            end
            OP_POP: begin
                ctl_o.dec = 1'b1;
            end
            OP_SET_TOP: begin
                ctl_o.wr = 1'b1;
            end
            OP_POP_SET: begin
                ctl_o.dec   = 1'b1;
                ctl_o.wr    = 1'b1;
                ctl_o.wr_dn = 1'b1;
            end
            default: ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/wrap_stack_ptr.sv
// Circular top-of-stack pointer. Assumes DEPTH is a power of two, so
// natural binary overflow gives the modulo wrap. Also provides the
// neighbouring indices used for reads and writes.
module wrap_stack_ptr #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          dec_i,
    output logic [PW-1:0] ptr_o,
    output logic [PW-1:0] ptr_up_o,
    output logic [PW-1:0] ptr_dn_o
);

    logic [PW-1:0] ptr_q;

    // Neighbour indices, wrapping naturally at the power-of-two width
    always_comb begin
        ptr_up_o = ptr_q + PW'(1);
        ptr_dn_o = ptr_q - PW'(1);
        ptr_o    = ptr_q;
    end

    // Pointer register: clear on reset, step up or down on request
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (inc_i)
            ptr_q <= ptr_up_o;
        else if (dec_i)
            ptr_q <= ptr_dn_o;
    end

endmodule

// File: rtl/wrap_stack_regs.sv
// Entry storage: DEPTH registers with one write port and two
// combinational read ports (top and second). Assumes one write per cycle.
module wrap_stack_regs #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [PW-1:0]    widx_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [PW-1:0]    ridx_top_i,
    input  logic [PW-1:0]    ridx_sec_i,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] sec_o
);

    logic [WIDTH-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // One entry: clear on reset, load when addressed by the write port
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (we_i && (widx_i == PW'(g)))
                ent_q[g] <= wdata_i;
        end
    end

    // Read ports for the two exposed entries
    always_comb begin
        top_o = ent_q[ridx_top_i];
        sec_o = ent_q[ridx_sec_i];
    end

endmodule

// File: rtl/wrap_stack.sv
// Per-slot wraparound operand stack: exposes top and second entries,
// supports idle, push, pop, replace top and pop-and-replace in one cycle.
// Assumes DEPTH is a power of two; no overflow or underflow is flagged.
module wrap_stack
    import wrap_stack_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] second_o
);

    localparam int PW = $clog2(DEPTH);

    stk_ctl_t      ctl;
    logic [PW-1:0] ptr, ptr_up, ptr_dn, widx;

    wrap_stack_dec u_dec (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    wrap_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (ctl.inc),
        .dec_i    (ctl.dec),
        .ptr_o    (ptr),
        .ptr_up_o (ptr_up),
        .ptr_dn_o (ptr_dn)
    );

    // Select the entry the write lands on: above, below or at the top
    always_comb begin
        if (ctl.wr_up)
            widx = ptr_up;
        else if (ctl.wr_dn)
            widx = ptr_dn;
        else
            widx = ptr;
    end

    wrap_stack_regs #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (ctl.wr),
        .widx_i     (widx),
        .wdata_i    (wdata_i),
        .ridx_top_i (ptr),
        .ridx_sec_i (ptr_dn),
        .top_o      (top_o),
        .sec_o      (second_o)
    );

endmodule

// File: rtl/wrap_stack_chk.sv
// Port-level checker for wrap_stack, attached by bind below.
// Assumes the operation codes of wrap_stack_pkg.
module wrap_stack_chk
    import wrap_stack_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] wdata_i,
    input logic [WIDTH-1:0] top_o,
    input logic [WIDTH-1:0] second_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (top_o == '0 && second_o == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_IDLE || op_i > OP_POP_SET) |=> ($stable(top_o) && $stable(second_o))); // R2

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_PUSH |=> top_o == $past(wdata_i)); // R3

    AST_PUSH_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_PUSH |=> second_o == $past(top_o)); // R3

    AST_POP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_POP |=> top_o == $past(second_o)); // R4

    AST_SET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_SET_TOP |=> (top_o == $past(wdata_i) && $stable(second_o))); // R5

    AST_POP_SET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_POP_SET |=> top_o == $past(wdata_i)); // R6

endmodule

bind wrap_stack wrap_stack_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .wdata_i  (wdata_i),
    .top_o    (top_o),
    .second_o (second_o)
);

// File: tb/sim_wrap_stack.sv
// Bench for wrap_stack: exhaustive three-operation sweeps from reset,
// a long pseudo-random run and directed wrap cases, checked against
// a circular-buffer expectation built from the requirements.
module sim_wrap_stack;

    localparam int W = 32;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [W-1:0] wd = '0;
    logic [W-1:0] top, sec;

    int tests = 0;
    int fails = 0;
    logic [W-1:0] mdl [D];
    int mp = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    wrap_stack u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op),
        .wdata_i  (wd),
        .top_o    (top),
        .second_o (sec)
    );

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag);
        logic [W-1:0] et, es;
        et = mdl[mp];
        es = mdl[(mp + D - 1) % D];
        tests++;
        if (top !== et || sec !== es) begin
            fails++;
            $display("FAIL %s: top=%h second=%h expected top=%h second=%h",
                     tag, top, sec, et, es);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        op = 3'd0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < D; i++) mdl[i] = '0;
        mp = 0;
        check("R1");
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [2:0] o, input logic [W-1:0] d, input string tag);
        op = o;
        wd = d;
        @(posedge clk);
        @(negedge clk);
        case (o)
            3'd1: begin mp = (mp + 1) % D; mdl[mp] = d; end
            3'd2: mp = (mp + D - 1) % D;
            3'd3: mdl[mp] = d;
            3'd4: begin mp = (mp + D - 1) % D; mdl[mp] = d; end
            default: ;
        endcase
        check(tag);
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();

        // R8: pop below the bottom right after reset shows zeros, no error
        step(3'd2, '0, "R8");
        step(3'd4, 32'hAAAA_0001, "R8");

        // Exhaustive sweep of all three-operation sequences over all codes
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int c = 0; c < 8; c++) begin
                    do_reset();
                    step(3'(a), 32'h1000_0000 + 32'(a), tag_of(3'(a)));
                    step(3'(b), 32'h2000_0000 + 32'(b), tag_of(3'(b)));
                    step(3'(c), 32'h3000_0000 + 32'(c), tag_of(3'(c)));
                end

        // R7: nine pushes wrap over the oldest entry, then unwind fully
        do_reset();
        for (int i = 1; i <= 9; i++) step(3'd1, 32'hC0DE_0000 + 32'(i), "R7");
        for (int i = 0; i < 10; i++) step(3'd2, '0, "R7");

        // Long pseudo-random mix of every code
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            lfsr = nxt(lfsr);
            step(lfsr[2:0], nxt(lfsr), tag_of(lfsr[2:0]));
        end

        // R1: reset in the middle of a populated stack
        for (int i = 0; i < 5; i++) step(3'd1, 32'hFEED_0000 + 32'(i), "R3");
        do_reset();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule